// File: doc/BRIEF.md
# DRAM Refresh Cycle Controller

This block keeps an asynchronous DRAM with 1024 rows alive. It issues refresh cycles on its row-strobe (`dram_ras_n`), column-strobe (`dram_cas_n`), write-enable (`dram_we_n`) and address pins. It also serves a simple host port for single read and write accesses. A free-running interval timer raises a refresh request every `cfg_interval` clocks.

Three refresh sequences are available through `cfg_mode`:
- **Row-strobe-only** (code 0): the controller drives the row from its own 10-bit counter.
- **Column-before-row** (codes 1 and 3): no address is driven, and the DRAM's internal counter advances.
- **Hidden** (code 2): the refresh is chained onto the tail of a host read.

`cfg_burst` picks the scheduling. In distributed scheduling each request gives one refresh cycle. In burst scheduling each request gives all 1024 cycles back to back.

A refresh sequence is never preempted. The host is stalled by holding off `host_gnt` until the sequence ends. An error flag records any request left waiting too long. The strobe timings are parameters in clock cycles:
- `T_RAS`: minimum row-strobe low time.
- `T_RP`: minimum row-strobe precharge time.
- `T_CSR`: column-to-row setup time.

The sequencer states and their transitions are listed below.

| State | Pins | Leaves to |
|---|---|---|
| IDLE | all high | HROW on host grant; ROR or CSET on a pending refresh |
| HROW | row strobe low, host row | HCOL after 1 cycle |
| HCOL | both strobes low, host column | HRH (read, hidden mode, refresh pending) or HPRE after T_RAS |
| HPRE | all high | IDLE after T_RP |
| ROR | row strobe low, counter row | RPRE after T_RAS |
| CSET | column strobe low | CLOW after T_CSR |
| CLOW | both strobes low | RPRE after T_RAS |
| HRH | row strobe high, column held low | HRL after T_RP |
| HRL | both strobes low | RPRE after T_RAS |
| RPRE | all high | next ROR/CSET in an unfinished burst, else IDLE, after T_RP |

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is held and right after it, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, and `ref_busy`, `burst_done` and `ref_err` are low.
- R2: A granted host access works as follows. `host_gnt` pulses for one cycle. The row strobe falls with `host_row` on `dram_addr`. The column strobe then falls with `host_col` on `dram_addr`. `dram_we_n` is low during that column phase when `host_we` is 1 and high when it is 0.
- R3: In mode 0, each refresh asserts only the row strobe, with the column strobe high. The row comes from an internal 10-bit counter that starts at 0 after reset, steps by one per refresh and wraps from 1023 to 0.
- R4: In modes 1 and 3, each refresh drops the column strobe at least T_CSR cycles before the row strobe falls, and drives address 0.
- R5: In mode 2, when a host read is granted or in progress while a refresh is pending, the refresh follows the read. The row strobe rises for T_RP cycles and falls again while the column strobe stays low throughout.
- R6: In mode 2, when a refresh is pending and no host read is waiting, a standalone column-before-row cycle is issued.
- R7: With `cfg_burst`=0, one refresh cycle runs per timer request, requests come every `cfg_interval` cycles, and `burst_done` never pulses.
- R8: With `cfg_burst`=1, one request yields exactly 1024 refresh cycles back to back. `ref_busy` stays high across the whole burst, and `burst_done` pulses for one cycle at its end.
- R9: `host_gnt` is never high while `ref_busy` is high. A host request made during a refresh is granted once the sequence ends.
- R10: The row strobe stays low at least T_RAS cycles and high at least T_RP cycles on every cycle type.
- R11: `ref_err` goes high once a refresh request has waited more than `cfg_max_wait` cycles without starting. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | 0 row-only, 1/3 column-before-row, 2 hidden |
| cfg_burst | input | 1 | 1 burst, 0 distributed scheduling |
| cfg_interval | input | CNT_W | Clocks between refresh requests |
| cfg_max_wait | input | CNT_W | Allowed wait of a pending request |
| host_req | input | 1 | Host access request, held until grant |
| host_we | input | 1 | 1 write, 0 read |
| host_row | input | ROW_W | Host row address |
| host_col | input | ROW_W | Host column address |
| host_gnt | output | 1 | One-cycle grant pulse |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | ROW_W | Multiplexed DRAM address |
| ref_busy | output | 1 | High during any refresh sequence |
| burst_done | output | 1 | Pulse at the end of a burst |
| ref_err | output | 1 | Sticky overdue-refresh flag |

## Verification
The hardest case to reach from the ports is the hidden refresh. It needs a refresh request and a host read to coincide, so that the refresh can ride on the read's column phase instead of falling back to a standalone cycle. The stimulus holds a read request high across a whole run in hidden mode. Every timer request then lands either during a read or with a read waiting, so every refresh should be chained. A bus monitor classifies each row-strobe fall by whether the column strobe was already low before the preceding precharge.

// File: rtl/dref_pkg.sv
package dref_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HROW,
        ST_HCOL,
        ST_HPRE,
        ST_ROR,
        ST_CSET,
        ST_CLOW,
        ST_HRH,
        ST_HRL,
        ST_RPRE
    } dref_state_e;

    localparam logic [1:0] MODE_ROR = 2'd0;
    localparam logic [1:0] MODE_CBR = 2'd1;
    localparam logic [1:0] MODE_HID = 2'd2;

endpackage

// File: rtl/dref_ctr.sv
module dref_ctr #(
    parameter int LIMIT = 1024,
    parameter int W     = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    logic at_end;
    assign at_end = (q == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (inc) q <= at_end ? '0 : q + 1'b1;
    end
endmodule

// File: rtl/dref_sched.sv
module dref_sched #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_interval,
    input  logic [CNT_W-1:0] cfg_max_wait,
    input  logic             start,
    output logic             pend,
    output logic             err
);
    logic [CNT_W-1:0] tmr;
    logic [CNT_W-1:0] wait_cnt;
    logic             tick;

    assign tick = (tmr == cfg_interval - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr      <= '0;
            pend     <= 1'b0;
            wait_cnt <= '0;
            err      <= 1'b0;
        end else begin
            tmr <= tick ? '0 : tmr + 1'b1;
            if (tick)       pend <= 1'b1;
            else if (start) pend <= 1'b0;
            if (!pend || start)       wait_cnt <= '0;
            else if (wait_cnt != '1)  wait_cnt <= wait_cnt + 1'b1;
            if (pend && !start && (wait_cnt >= cfg_max_wait)) err <= 1'b1;
        end
    end
endmodule

// File: rtl/dref_fsm.sv
module dref_fsm
    import dref_pkg::*;
#(
    parameter int T_RAS = 3,
    parameter int T_RP  = 2,
    parameter int T_CSR = 1,
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_burst,
    input  logic             host_req,
    input  logic             host_we,
    input  logic [ROW_W-1:0] host_row,
    input  logic [ROW_W-1:0] host_col,
    input  logic             pend,
    input  logic [ROW_W-1:0] row_q,
    input  logic             bcnt_last,
    output logic             host_gnt,
    output logic             ref_start,
    output logic             row_inc,
    output logic             bcnt_inc,
    output logic             burst_done,
    output logic             ref_busy,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] addr
);
    localparam int PH_W = $clog2(T_RAS + T_RP + T_CSR + 1);

    dref_state_e      state, nxt, start_st;
    logic [PH_W-1:0]  ph_cnt;
    logic             ph_done, ref_end, burst_on, we_l;
    logic [ROW_W-1:0] row_l, col_l;

    function automatic logic [PH_W-1:0] dur(input dref_state_e s);
        case (s)
            ST_HCOL, ST_ROR, ST_CLOW, ST_HRL: dur = PH_W'(T_RAS - 1);
            ST_HPRE, ST_HRH, ST_RPRE:         dur = PH_W'(T_RP - 1);
            ST_CSET:                          dur = PH_W'(T_CSR - 1);
            default:                          dur = '0;
        endcase
    endfunction

    assign ph_done    = (ph_cnt == '0);
    assign start_st   = (cfg_mode == MODE_ROR) ? ST_ROR : ST_CSET;
    assign bcnt_inc   = ref_end && burst_on;
    assign burst_done = ref_end && burst_on && bcnt_last;

    // next state and strobes
    always_comb begin
        nxt       = state;
        host_gnt  = 1'b0;
        ref_start = 1'b0;
        row_inc   = 1'b0;
        ref_end   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (pend) begin
                    if (cfg_mode == MODE_HID && host_req && !host_we) begin
                        nxt      = ST_HROW;
                        host_gnt = 1'b1;
                    end else begin
                        nxt       = start_st;
                        ref_start = 1'b1;
                    end
                end else if (host_req) begin
                    nxt      = ST_HROW;
                    host_gnt = 1'b1;
                end
            end
            ST_HROW: if (ph_done) nxt = ST_HCOL;
            ST_HCOL: begin
                if (ph_done) begin
                    if (!we_l && cfg_mode == MODE_HID && pend) begin
                        nxt       = ST_HRH;
                        ref_start = 1'b1;
                    end else begin
                        nxt = ST_HPRE;
                    end
                end
            end
            ST_HPRE: if (ph_done) nxt = ST_IDLE;
            ST_ROR: begin
                if (ph_done) begin
                    nxt     = ST_RPRE;
                    row_inc = 1'b1;
                end
            end
            ST_CSET: if (ph_done) nxt = ST_CLOW;
            ST_CLOW: if (ph_done) nxt = ST_RPRE;
            ST_HRH:  if (ph_done) nxt = ST_HRL;
            ST_HRL:  if (ph_done) nxt = ST_RPRE;
            ST_RPRE: begin
                if (ph_done) begin
                    ref_end = 1'b1;
                    nxt     = (burst_on && !bcnt_last) ? start_st : ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ph_cnt   <= '0;
            burst_on <= 1'b0;
            we_l     <= 1'b0;
            row_l    <= '0;
            col_l    <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) ph_cnt <= dur(nxt);
            else if (!ph_done) ph_cnt <= ph_cnt - 1'b1;
            if (host_gnt) begin
                we_l  <= host_we;
                row_l <= host_row;
                col_l <= host_col;
            end
            if (ref_start)       burst_on <= cfg_burst;
            else if (burst_done) burst_on <= 1'b0;
        end
    end

    // pin outputs
    always_comb begin
        ras_n    = 1'b1;
        cas_n    = 1'b1;
        we_n     = 1'b1;
        addr     = '0;
        ref_busy = 1'b0;
        unique case (state)
            ST_HROW: begin ras_n = 1'b0; addr = row_l; end
            ST_HCOL: begin ras_n = 1'b0; cas_n = 1'b0; we_n = !we_l; addr = col_l; end
            ST_ROR:  begin ras_n = 1'b0; addr = row_q; ref_busy = 1'b1; end
            ST_CSET: begin cas_n = 1'b0; ref_busy = 1'b1; end
            ST_CLOW: begin ras_n = 1'b0; cas_n = 1'b0; ref_busy = 1'b1; end
            ST_HRH:  begin cas_n = 1'b0; ref_busy = 1'b1; end
            ST_HRL:  begin ras_n = 1'b0; cas_n = 1'b0; ref_busy = 1'b1; end
            ST_RPRE: ref_busy = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
    parameter int ROWS  = 1024,
    parameter int CNT_W = 16,
    parameter int T_RAS = 3,
    parameter int T_RP  = 2,
    parameter int T_CSR = 1,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_burst,
    input  logic [CNT_W-1:0] cfg_interval,
    input  logic [CNT_W-1:0] cfg_max_wait,
    input  logic             host_req,
    input  logic             host_we,
    input  logic [ROW_W-1:0] host_row,
    input  logic [ROW_W-1:0] host_col,
    output logic             host_gnt,
    output logic             dram_ras_n,
    output logic             dram_cas_n,
    output logic             dram_we_n,
    output logic [ROW_W-1:0] dram_addr,
    output logic             ref_busy,
    output logic             burst_done,
    output logic             ref_err
);
    logic             pend, ref_start, row_inc, bcnt_inc, bcnt_last;
    logic [ROW_W-1:0] row_q, bcnt_q;

    assign bcnt_last = (bcnt_q == ROW_W'(ROWS - 1));

    dref_sched #(.CNT_W(CNT_W)) u_sched (
        .clk(clk), .rst_n(rst_n),
        .cfg_interval(cfg_interval), .cfg_max_wait(cfg_max_wait),
        .start(ref_start), .pend(pend), .err(ref_err)
    );

    dref_ctr #(.LIMIT(ROWS), .W(ROW_W)) u_rowc (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .inc(row_inc), .q(row_q)
    );

    dref_ctr #(.LIMIT(ROWS), .W(ROW_W)) u_bcnt (
        .clk(clk), .rst_n(rst_n), .clr(ref_start), .inc(bcnt_inc), .q(bcnt_q)
    );

    dref_fsm #(.T_RAS(T_RAS), .T_RP(T_RP), .T_CSR(T_CSR), .ROW_W(ROW_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cfg_mode(cfg_mode), .cfg_burst(cfg_burst),
        .host_req(host_req), .host_we(host_we),
        .host_row(host_row), .host_col(host_col),
        .pend(pend), .row_q(row_q), .bcnt_last(bcnt_last),
        .host_gnt(host_gnt), .ref_start(ref_start), .row_inc(row_inc),
        .bcnt_inc(bcnt_inc), .burst_done(burst_done), .ref_busy(ref_busy),
        .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .addr(dram_addr)
    );
endmodule

// File: rtl/dref_chk.sv
module dref_chk #(
    parameter int T_RAS = 3,
    parameter int T_RP  = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic [1:0] mode,
    input logic       busy,
    input logic       gnt,
    input logic       err,
    input logic       done
);
    logic [7:0] lo_cnt, hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= 8'd0;
            hi_cnt <= 8'hFF;
        end else begin
            lo_cnt <= ras_n ? 8'd0 : ((lo_cnt == 8'hFF) ? lo_cnt : lo_cnt + 8'd1);
            hi_cnt <= !ras_n ? 8'd0 : ((hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 8'd1);
        end
    end

    AST_RAS_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && lo_cnt != 8'd0) |-> (lo_cnt >= 8'(T_RAS))); // R10
    AST_RAS_PRE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && hi_cnt != 8'd0) |-> (hi_cnt >= 8'(T_RP))); // R10
    AST_ROR_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && busy && mode == 2'd0) |-> cas_n); // R3
    AST_CBR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> !$past(cas_n)); // R4
    AST_GNT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |-> !busy); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R8
endmodule

bind dram_refresh_ctrl dref_chk #(.T_RAS(T_RAS), .T_RP(T_RP)) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
    .mode(cfg_mode), .busy(ref_busy), .gnt(host_gnt), .err(ref_err),
    .done(burst_done)
);

// File: tb/dram_refresh_ctrl_test.sv
module dram_refresh_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int T_RAS = 3;
    localparam int T_RP  = 2;
    localparam int RUN   = 1000;
    localparam int NVEC  = 5;
    // {mode[1:0], host_read, interval[15:0], kind[1:0]} kind: 0 row-only, 1 col-before-row, 2 hidden
    localparam logic [20:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 16'd50, 2'd0},
        {2'd1, 1'b0, 16'd50, 2'd1},
        {2'd2, 1'b1, 16'd50, 2'd2},
        {2'd2, 1'b0, 16'd50, 2'd1},
        {2'd3, 1'b0, 16'd40, 2'd1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] cfg_mode = '0;
    logic cfg_burst = 1'b0;
    logic [15:0] cfg_interval = 16'd100, cfg_max_wait = 16'd100;
    logic host_req = 1'b0, host_we = 1'b0;
    logic [9:0] host_row = '0, host_col = '0;
    logic host_gnt, ras, cas, we_n, busy, done, err;
    logic [9:0] addr;

    int checks = 0, failures = 0, cyc = 0;
    int ror_cnt, cbr_cnt, hid_cnt, host_ras, viol_t, viol_row, viol_addr, viol_gnt;
    int busy_falls, done_cnt, lo_run, hi_run, cas_run, exp_row;
    logic p_ras, p_cas, p_busy, cap_we;
    logic [9:0] cap_row, cap_col;

    dram_refresh_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_burst(cfg_burst),
        .cfg_interval(cfg_interval), .cfg_max_wait(cfg_max_wait),
        .host_req(host_req), .host_we(host_we), .host_row(host_row), .host_col(host_col),
        .host_gnt(host_gnt), .dram_ras_n(ras), .dram_cas_n(cas), .dram_we_n(we_n),
        .dram_addr(addr), .ref_busy(busy), .burst_done(done), .ref_err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // bus monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            ror_cnt = 0; cbr_cnt = 0; hid_cnt = 0; host_ras = 0;
            viol_t = 0; viol_row = 0; viol_addr = 0; viol_gnt = 0;
            busy_falls = 0; done_cnt = 0; exp_row = 0;
            lo_run = 0; hi_run = 1000; cas_run = 0;
            p_ras = 1'b1; p_cas = 1'b1; p_busy = 1'b0;
        end else begin
            if (p_ras && !ras) begin
                if (hi_run < T_RP) viol_t++;
                if (busy && cas) begin
                    ror_cnt++;
                    if (int'(addr) != exp_row) viol_row++;
                    exp_row = (exp_row + 1) % 1024;
                end else if (!cas) begin
                    if (cas_run > hi_run) hid_cnt++;
                    else cbr_cnt++;
                    if (addr != 10'd0) viol_addr++;
                end else begin
                    host_ras++;
                    cap_row = addr;
                end
            end
            if (!p_ras && ras && lo_run < T_RAS) viol_t++;
            if (p_cas && !cas && !ras && !busy) begin
                cap_col = addr;
                cap_we  = we_n;
            end
            if (host_gnt && busy) viol_gnt++;
            if (p_busy && !busy) busy_falls++;
            if (done) done_cnt++;
            lo_run  = ras ? 0 : lo_run + 1;
            hi_run  = ras ? hi_run + 1 : 0;
            cas_run = cas ? 0 : cas_run + 1;
            p_ras = ras; p_cas = cas; p_busy = busy;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m, input logic b, input logic [15:0] iv, input logic [15:0] mw);
        @(negedge clk);
        rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0;
        cfg_mode = m; cfg_burst = b; cfg_interval = iv; cfg_max_wait = mw;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic host_op(input logic w, input logic [9:0] r, input logic [9:0] c);
        host_req = 1'b1; host_we = w; host_row = r; host_col = c;
        #1;
        while (!host_gnt) @(negedge clk);
        @(negedge clk);
        host_req = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        // R1: reset values
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(ras && cas && we_n, "R1", "strobes high in reset", {ras, cas, we_n}, 7);
        chk(!busy && !done && !err, "R1", "flags low in reset", {busy, done, err}, 0);

        // table of refresh modes in distributed scheduling
        for (int i = 0; i < NVEC; i++) begin
            logic [20:0] v;
            int n, got;
            string tag;
            v = VEC[i];
            tag = (i == 0) ? "R3" : (i == 2) ? "R5" : (i == 3) ? "R6" : "R4";
            do_reset(v[20:19], 1'b0, v[17:2], 16'd100);
            host_req = v[18]; host_we = 1'b0;
            repeat (RUN) @(negedge clk);
            host_req = 1'b0;
            repeat (20) @(negedge clk);
            n = RUN / int'(v[17:2]);
            got = (v[1:0] == 2'd0) ? ror_cnt : (v[1:0] == 2'd1) ? cbr_cnt : hid_cnt;
            chk(got >= n - 2 && got <= n, "R7", {tag, " refreshes per interval"}, got, n);
            chk(ror_cnt + cbr_cnt + hid_cnt == got, tag, "no other refresh type",
                ror_cnt + cbr_cnt + hid_cnt, got);
            chk(viol_row == 0, "R3", "row counter sequence", viol_row, 0);
            chk(viol_addr == 0, "R4", "address zero on column-first refresh", viol_addr, 0);
            chk(viol_t == 0, "R10", "strobe widths", viol_t, 0);
            chk(viol_gnt == 0, "R9", "no grant while busy", viol_gnt, 0);
            chk(done_cnt == 0, "R7", "no burst_done in distributed", done_cnt, 0);
            chk(err == 1'b0, "R11", "no error in normal run", err, 0);
            if (v[18]) chk(host_ras > 0, "R2", "host reads served", host_ras, 1);
        end

        // R2: host write and read
        do_reset(2'd1, 1'b0, 16'd60000, 16'd100);
        @(negedge clk);
        chk(ras && cas && we_n && !busy && !err, "R1", "idle after reset", {ras, cas, we_n, busy, err}, 7);
        host_op(1'b1, 10'h2A5, 10'h13C);
        chk(cap_row == 10'h2A5, "R2", "write row address", cap_row, 10'h2A5);
        chk(cap_col == 10'h13C, "R2", "write column address", cap_col, 10'h13C);
        chk(cap_we == 1'b0, "R2", "we_n low on write", cap_we, 0);
        host_op(1'b0, 10'h0F0, 10'h301);
        chk(cap_row == 10'h0F0 && cap_col == 10'h301, "R2", "read addresses", {cap_row, cap_col}, {10'h0F0, 10'h301});
        chk(cap_we == 1'b1, "R2", "we_n high on read", cap_we, 1);
        chk(host_ras == 2 && ror_cnt + cbr_cnt + hid_cnt == 0, "R2", "two host cycles only", host_ras, 2);

        // R8, R9, R3 wrap: two row-only bursts
        do_reset(2'd0, 1'b1, 16'd6000, 16'd60000);
        while (done_cnt < 1) @(posedge clk);
        @(negedge clk); #1;
        chk(ror_cnt == 1024, "R8", "refreshes in first burst", ror_cnt, 1024);
        chk(busy_falls == 1, "R8", "busy continuous across burst", busy_falls, 1);
        while (!busy) @(posedge clk);
        repeat (100) @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_row = 10'h011; host_col = 10'h022;
        #1;
        while (!host_gnt) @(negedge clk);
        chk(!busy && done_cnt == 2, "R9", "host granted only after burst", done_cnt, 2);
        @(negedge clk);
        host_req = 1'b0;
        repeat (12) @(negedge clk);
        chk(ror_cnt == 2048, "R8", "refreshes in two bursts", ror_cnt, 2048);
        chk(viol_row == 0, "R3", "row wrap 1023 to 0", viol_row, 0);
        chk(host_ras == 1, "R9", "held request served once", host_ras, 1);
        chk(viol_t == 0 && viol_gnt == 0, "R10", "widths and grants in burst", viol_t + viol_gnt, 0);

        // R11: overdue request during a long burst
        do_reset(2'd1, 1'b1, 16'd100, 16'd20);
        repeat (150) @(negedge clk);
        chk(err == 1'b0, "R11", "no error when served at once", err, 0);
        repeat (250) @(negedge clk);
        chk(err == 1'b1, "R11", "error after overdue wait", err, 1);
        repeat (200) @(negedge clk);
        chk(err == 1'b1, "R11", "error sticky", err, 1);
        chk(cbr_cnt > 0 && viol_addr == 0, "R4", "column-first burst cycles", cbr_cnt, 1);
        do_reset(2'd1, 1'b0, 16'd100, 16'd20);
        @(negedge clk);
        chk(err == 1'b0, "R1", "error cleared by reset", err, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule